// File: doc/BRIEF.md
# Keypad Scanner with Confirmation Tone

This block sits between a telephone keypad matrix and the dialing logic of a repertory dialer. It leaves the keypad quiet until one of the sense lines is pulled low. It then samples the row lines and the column lines in alternate half periods. Once it has seen a closure on both sides, it waits out a fixed debounce interval and reads the matrix again. A clean single key is reported as a four-bit code with a one-cycle strobe and a level that stays high while the key is down.

A short audible confirmation is produced as a square wave on `pacifier_out`. Whether it plays depends on the dialing mode, on whether programming is in progress, and on whether the key is a signalling digit or a function key. In tone mode, pressing several keys that share one row, or several that share one column, is treated as a single-frequency test request and is flagged on its own outputs. A disable input blinds the scanner to the keypad. All timing is counted in pulses of an external 1 ms tick.

Top module: `keypad_scanner`

## Requirements
- R1: With no sense line low, `scan_active` stays 0. After a line goes low, `scan_active` rises and the sampled side alternates every HALF_MS ticks. `scan_cols`=0 means rows are sampled and 1 means columns are sampled, giving a 250 Hz scan with the default value.
- R2: A key is accepted only when exactly one row and exactly one column are active at the end of a DEB_MS-tick (32 ms) debounce. On acceptance `key_valid` pulses for one clock with `key_code`, and `key_held` rises.
- R3: Line changes inside the debounce window are ignored. A press released before the window ends produces no strobe and no tone.
- R4: Code map for row r and column c (0-based): for r,c<3 the code is 3r+c+1. In row 3, column 0 gives 10 (star), column 1 gives 0 and column 2 gives 11 (pound). Column 3 gives 12+r, so rows 0 to 3 map to PROG=12, MEM=13, LND=14 and FLASH=15. Codes 12 to 15 are function keys.
- R5: The tone starts high in the cycle after acceptance and toggles on every tick (500 Hz). It stops when the key is released or after PAC_MS ticks (30 ms), giving 15 high pulses for a key held long enough.
- R6: The tone plays for every key when `tone_mode`=0 (pulse) or `prog_mode`=1. Otherwise it plays only for codes 12 to 15.
- R7: With `tone_mode`=1, one row plus two or more columns, or one column plus two or more rows, at debounce end raises `single_tone` until release with no `key_valid`. In the first case `test_col`=0 and `test_idx` is the row; in the second case `test_col`=1 and `test_idx` is the column. With `tone_mode`=0 the same pattern yields nothing.
- R8: While `chip_dis`=1 every sense line is treated as released: no scan starts and no key is reported.
- R9: After acceptance no further key is reported until every line is released and the block has returned to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-clock pulse every millisecond |
| row_n | input | 4 | Row sense lines, low = closed |
| col_n | input | NCOL | Column sense lines, low = closed |
| tone_mode | input | 1 | 1 = tone dialing, 0 = pulse dialing |
| prog_mode | input | 1 | Programming sequence in progress |
| chip_dis | input | 1 | Ignore keypad while high |
| scan_active | output | 1 | Scanner is sampling the matrix |
| scan_cols | output | 1 | 1 = column side sampled, 0 = row side |
| key_valid | output | 1 | One-clock acceptance strobe |
| key_code | output | 4 | Code of the accepted key |
| key_held | output | 1 | Accepted key still down |
| single_tone | output | 1 | Single-frequency test condition |
| test_col | output | 1 | Test line is a column (1) or a row (0) |
| test_idx | output | 2 | Index of the test line |
| pacifier_out | output | 1 | Confirmation square wave |

## Verification
Acceptance and the start of the confirmation tone fall in the same clock. In that cycle the tone generator also receives the held level, so a release arriving there must not leave the tone running. The bench provokes the overlap with every vector in the table. It judges it by counting the strobes, the tone's rising edges and the final tone level: 15 edges for a long hold, and fewer than 15 with the output low shortly after an early release.

// File: rtl/kp_pkg.sv
package kp_pkg;
    parameter int unsigned KP_ROWS = 4;
    parameter int unsigned KP_COLS = 4;
    localparam int unsigned IDX_W  = $clog2(KP_COLS);
    localparam int unsigned CODE_W = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_SCAN, S_DEB, S_HELD, S_TEST, S_WAIT
    } scan_state_e;

    typedef struct packed {
        logic              single;
        logic [CODE_W-1:0] code;
        logic              is_func;
        logic              st_ok;
        logic              st_col;
        logic [IDX_W-1:0]  st_idx;
    } dec_t;

    function automatic logic [CODE_W-1:0] key_code_f(int unsigned r, int unsigned c);
        logic [CODE_W-1:0] v;
        if (c == 3)          v = CODE_W'(12 + r);
        else if (r < 3)      v = CODE_W'(3 * r + c + 1);
        else if (c == 0)     v = CODE_W'(10);
        else if (c == 1)     v = CODE_W'(0);
        else                 v = CODE_W'(11);
        return v;
    endfunction
endpackage

// File: rtl/kp_decode.sv
module kp_decode
    import kp_pkg::*;
#(
    parameter int unsigned NCOL = 4
) (
    input  logic [KP_ROWS-1:0] row_act,
    input  logic [NCOL-1:0]    col_act,
    output dec_t               dec
);
    logic [IDX_W-1:0] ridx, cidx;
    int unsigned      rc, cc;

    always_comb begin
        ridx = '0;
        cidx = '0;
        for (int i = KP_ROWS - 1; i >= 0; i--) if (row_act[i]) ridx = IDX_W'(i);
        for (int j = NCOL - 1; j >= 0; j--)    if (col_act[j]) cidx = IDX_W'(j);
        rc = $countones(row_act);
        cc = $countones(col_act);
        dec.single  = (rc == 1) && (cc == 1);
        dec.code    = key_code_f(int'(ridx), int'(cidx));
        dec.is_func = dec.code >= CODE_W'(12);
        dec.st_col  = (cc == 1) && (rc >= 2);
        dec.st_ok   = ((rc == 1) && (cc >= 2)) || dec.st_col;
        dec.st_idx  = dec.st_col ? cidx : ridx;
    end
endmodule

// File: rtl/kp_scan_ctrl.sv
module kp_scan_ctrl
    import kp_pkg::*;
#(
    parameter int unsigned NCOL    = 4,
    parameter int unsigned HALF_MS = 2,
    parameter int unsigned DEB_MS  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [KP_ROWS-1:0] row_act,
    input  logic [NCOL-1:0]    col_act,
    input  logic               tone_mode,
    input  logic               prog_mode,
    input  dec_t               dec,
    output logic               scan_active,
    output logic               scan_cols,
    output logic               key_valid,
    output logic [CODE_W-1:0]  key_code,
    output logic               key_held,
    output logic               single_tone,
    output logic               test_col,
    output logic [IDX_W-1:0]   test_idx,
    output logic               pac_start
);
    localparam int unsigned TMAX = (DEB_MS > HALF_MS) ? DEB_MS : HALF_MS;
    localparam int unsigned CW   = $clog2(TMAX + 1);

    scan_state_e        state;
    logic [CW-1:0]      tcnt;
    logic               phase;
    logic [KP_ROWS-1:0] row_snap;
    logic               any_act;

    assign any_act = (|row_act) || (|col_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            tcnt      <= '0;
            phase     <= 1'b0;
            row_snap  <= '0;
            key_valid <= 1'b0;
            pac_start <= 1'b0;
            key_code  <= '0;
            test_col  <= 1'b0;
            test_idx  <= '0;
        end else begin
            key_valid <= 1'b0;
            pac_start <= 1'b0;
            case (state)
                S_IDLE: begin
                    phase <= 1'b0;
                    tcnt  <= '0;
                    if (any_act) state <= S_SCAN;
                end
                S_SCAN: if (tick) begin
                    if (tcnt == CW'(HALF_MS - 1)) begin
                        tcnt  <= '0;
                        phase <= ~phase;
                        if (!phase) begin
                            row_snap <= row_act;
                        end else if ((|row_snap) && (|col_act)) begin
                            state <= S_DEB;
                        end else if (!any_act) begin
                            state <= S_IDLE;
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                S_DEB: if (tick) begin
                    if (tcnt == CW'(DEB_MS - 1)) begin
                        tcnt <= '0;
                        if (dec.single) begin
                            state     <= S_HELD;
                            key_valid <= 1'b1;
                            key_code  <= dec.code;
                            pac_start <= prog_mode || !tone_mode || dec.is_func;
                        end else if (tone_mode && dec.st_ok) begin
                            state    <= S_TEST;
                            test_col <= dec.st_col;
                            test_idx <= dec.st_idx;
                        end else begin
                            state <= S_WAIT;
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: if (!any_act) state <= S_IDLE;
            endcase
        end
    end

    assign scan_active = (state == S_SCAN);
    assign scan_cols   = (state == S_SCAN) && phase;
    assign key_held    = (state == S_HELD);
    assign single_tone = (state == S_TEST);

    // R1: a quiet keypad in idle keeps the scanner stopped
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !any_act) |=> !scan_active);
    // R2: a strobe follows a sample of exactly one row and one column
    p_single_key_r2: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> ($countones($past(row_act)) == 1 && $countones($past(col_act)) == 1));
    // R7: the test condition only appears when tone mode was set
    p_test_tone_only_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(single_tone) |-> $past(tone_mode));
    // R9: while a key is held, no second strobe is issued
    p_no_repeat_r9: assert property (@(posedge clk) disable iff (rst)
        (key_held && $past(key_held)) |-> !key_valid);
endmodule

// File: rtl/kp_pacifier.sv
module kp_pacifier #(
    parameter int unsigned PAC_MS = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    input  logic held,
    output logic pac_out
);
    localparam int unsigned PW = $clog2(PAC_MS + 1);

    logic          on, sq;
    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            on   <= 1'b0;
            sq   <= 1'b0;
            pcnt <= '0;
        end else if (start) begin
            on   <= 1'b1;
            sq   <= 1'b1;
            pcnt <= '0;
        end else if (on) begin
            if (!held) begin
                on <= 1'b0;
            end else if (tick) begin
                if (pcnt == PW'(PAC_MS - 1)) begin
                    on <= 1'b0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                    sq   <= ~sq;
                end
            end
        end
    end

    assign pac_out = on && sq;

    // R5: the burst never outlasts its window
    p_pac_window_r5: assert property (@(posedge clk) disable iff (rst)
        on |-> (pcnt < PW'(PAC_MS)));
    // R5: release silences the tone on the next clock
    p_pac_release_r5: assert property (@(posedge clk) disable iff (rst)
        (!held && !start) |=> !pac_out);
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import kp_pkg::*;
#(
    parameter int unsigned NCOL    = 4,
    parameter int unsigned HALF_MS = 2,
    parameter int unsigned DEB_MS  = 32,
    parameter int unsigned PAC_MS  = 30
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_1ms,
    input  logic [KP_ROWS-1:0] row_n,
    input  logic [NCOL-1:0]    col_n,
    input  logic               tone_mode,
    input  logic               prog_mode,
    input  logic               chip_dis,
    output logic               scan_active,
    output logic               scan_cols,
    output logic               key_valid,
    output logic [CODE_W-1:0]  key_code,
    output logic               key_held,
    output logic               single_tone,
    output logic               test_col,
    output logic [IDX_W-1:0]   test_idx,
    output logic               pacifier_out
);
    logic [KP_ROWS-1:0] row_act;
    logic [NCOL-1:0]    col_act;
    dec_t               dec;
    logic               pac_start;

    assign row_act = chip_dis ? '0 : ~row_n;
    assign col_act = chip_dis ? '0 : ~col_n;

    kp_decode #(.NCOL(NCOL)) u_dec (
        .row_act (row_act),
        .col_act (col_act),
        .dec     (dec)
    );

    kp_scan_ctrl #(.NCOL(NCOL), .HALF_MS(HALF_MS), .DEB_MS(DEB_MS)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_1ms),
        .row_act     (row_act),
        .col_act     (col_act),
        .tone_mode   (tone_mode),
        .prog_mode   (prog_mode),
        .dec         (dec),
        .scan_active (scan_active),
        .scan_cols   (scan_cols),
        .key_valid   (key_valid),
        .key_code    (key_code),
        .key_held    (key_held),
        .single_tone (single_tone),
        .test_col    (test_col),
        .test_idx    (test_idx),
        .pac_start   (pac_start)
    );

    kp_pacifier #(.PAC_MS(PAC_MS)) u_pac (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1ms),
        .start   (pac_start),
        .held    (key_held),
        .pac_out (pacifier_out)
    );

    // R8: a disabled keypad never yields a strobe
    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        chip_dis |=> !key_valid);
endmodule

// File: tb/tb_keypad_scanner.sv
module tb_keypad_scanner;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1ms = 1'b0;
    logic       tone_mode = 1'b0, prog_mode = 1'b0, chip_dis = 1'b0;
    logic [15:0] kmat = '0;
    logic [3:0] row_n, col_n;
    logic       scan_active, scan_cols, key_valid, key_held, single_tone, test_col, pacifier_out;
    logic [3:0] key_code;
    logic [1:0] test_idx;

    int checks = 0, fails = 0;
    int nvalid = 0, nrise = 0;
    logic [3:0] last_code = '0;
    logic prev_pac = 1'b0;
    int tcnt = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        tcnt     <= (tcnt == 9) ? 0 : tcnt + 1;
        tick_1ms <= (tcnt == 9);
    end

    always_comb begin
        for (int r = 0; r < 4; r++) row_n[r] = ~|kmat[r*4 +: 4];
        for (int c = 0; c < 4; c++) col_n[c] = ~(kmat[c] | kmat[4+c] | kmat[8+c] | kmat[12+c]);
    end

    always @(posedge clk) begin
        if (key_valid) begin
            nvalid    <= nvalid + 1;
            last_code <= key_code;
        end
        if (pacifier_out && !prev_pac) nrise <= nrise + 1;
        prev_pac <= pacifier_out;
    end

    keypad_scanner dut (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .row_n(row_n), .col_n(col_n),
        .tone_mode(tone_mode), .prog_mode(prog_mode), .chip_dis(chip_dis),
        .scan_active(scan_active), .scan_cols(scan_cols), .key_valid(key_valid),
        .key_code(key_code), .key_held(key_held), .single_tone(single_tone),
        .test_col(test_col), .test_idx(test_idx), .pacifier_out(pacifier_out)
    );

    // {row[10:9], col[8:7], tone[6], prog[5], code[4:1], pacifier[0]}
    localparam int NV = 12;
    localparam logic [10:0] VEC [NV] = '{
        {2'd0, 2'd0, 1'b0, 1'b0, 4'd1,  1'b1},
        {2'd1, 2'd1, 1'b1, 1'b0, 4'd5,  1'b0},
        {2'd2, 2'd2, 1'b1, 1'b0, 4'd9,  1'b0},
        {2'd3, 2'd1, 1'b1, 1'b0, 4'd0,  1'b0},
        {2'd3, 2'd0, 1'b0, 1'b0, 4'd10, 1'b1},
        {2'd3, 2'd2, 1'b1, 1'b0, 4'd11, 1'b0},
        {2'd0, 2'd3, 1'b1, 1'b0, 4'd12, 1'b1},
        {2'd1, 2'd3, 1'b1, 1'b0, 4'd13, 1'b1},
        {2'd2, 2'd3, 1'b0, 1'b0, 4'd14, 1'b1},
        {2'd3, 2'd3, 1'b1, 1'b0, 4'd15, 1'b1},
        {2'd0, 2'd2, 1'b1, 1'b1, 4'd3,  1'b1},
        {2'd2, 2'd0, 1'b0, 1'b1, 4'd7,  1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) @(posedge clk iff tick_1ms);
        @(negedge clk);
    endtask

    task automatic set_keys(input logic [15:0] m);
        @(posedge clk iff tick_1ms);
        @(negedge clk);
        kmat = m;
    endtask

    function automatic logic [15:0] kbit(input int r, input int c);
        return 16'(1) << (r * 4 + c);
    endfunction

    initial begin
        int v0, r0;
        repeat (5) @(negedge clk);
        check(!scan_active && !key_valid && !key_held && !single_tone && !pacifier_out,
              "reset", int'({scan_active, key_valid, key_held, single_tone, pacifier_out}), 0);
        rst = 1'b0;
        wait_ticks(3);
        check(!scan_active, "R1 idle", scan_active, 0);

        for (int i = 0; i < NV; i++) begin
            logic [10:0] e;
            e = VEC[i];
            tone_mode = e[6];
            prog_mode = e[5];
            v0 = nvalid; r0 = nrise;
            set_keys(kbit(int'(e[10:9]), int'(e[8:7])));
            if (i == 0) begin
                wait_ticks(1);
                check(scan_active && !scan_cols, "R1 row phase", scan_cols, 0);
                wait_ticks(2);
                check(scan_active && scan_cols, "R1 col phase", scan_cols, 1);
                wait_ticks(67);
            end else begin
                wait_ticks(70);
            end
            check(nvalid - v0 == 1, "R2 strobe count", nvalid - v0, 1);
            check(last_code == e[4:1], "R4 key code", last_code, int'(e[4:1]));
            check(key_held, "R2 held", key_held, 1);
            check(nrise - r0 == (e[0] ? 15 : 0), "R6 pacifier pulses", nrise - r0, e[0] ? 15 : 0);
            check(!pacifier_out, "R5 timeout", pacifier_out, 0);
            kmat = '0;
            wait_ticks(3);
            check(!key_held && !scan_active, "R9 release", key_held, 0);
        end

        // R3: short press gives nothing
        tone_mode = 1'b0; prog_mode = 1'b0;
        v0 = nvalid; r0 = nrise;
        set_keys(kbit(1, 0));
        wait_ticks(20);
        kmat = '0;
        wait_ticks(30);
        check(nvalid == v0 && nrise == r0 && !key_held, "R3 short press", nvalid - v0, 0);

        // R3: bounce inside the debounce window is ignored
        v0 = nvalid;
        set_keys(kbit(2, 1));
        wait_ticks(10);
        kmat = '0;
        wait_ticks(3);
        kmat = kbit(2, 1);
        wait_ticks(40);
        check(nvalid - v0 == 1 && last_code == 4'd8, "R3 bounce", last_code, 8);
        // R9: extra key while held is not reported
        kmat = kbit(2, 1) | kbit(0, 0);
        wait_ticks(50);
        check(nvalid - v0 == 1, "R9 second key", nvalid - v0, 1);
        kmat = '0;
        wait_ticks(3);
        set_keys(kbit(0, 1));
        wait_ticks(40);
        check(nvalid - v0 == 2 && last_code == 4'd2, "R9 after idle", last_code, 2);

        // R5: early release silences the tone
        kmat = '0;
        wait_ticks(3);
        r0 = nrise;
        set_keys(kbit(1, 2));
        wait_ticks(41);
        kmat = '0;
        wait_ticks(2);
        check(nrise - r0 > 0 && nrise - r0 < 15 && !pacifier_out, "R5 early release", nrise - r0, 3);

        // R7: single tone, one row with two columns
        tone_mode = 1'b1;
        v0 = nvalid;
        set_keys(kbit(1, 0) | kbit(1, 2));
        wait_ticks(40);
        check(single_tone && !test_col && test_idx == 2'd1 && nvalid == v0,
              "R7 row test", int'({single_tone, test_col, test_idx}), 'b1001);
        kmat = '0;
        wait_ticks(3);
        check(!single_tone, "R7 test release", single_tone, 0);
        // R7: one column with two rows
        set_keys(kbit(0, 2) | kbit(3, 2));
        wait_ticks(40);
        check(single_tone && test_col && test_idx == 2'd2, "R7 column test",
              int'({single_tone, test_col, test_idx}), 'b1110);
        kmat = '0;
        wait_ticks(3);
        // R7: pulse mode gives nothing
        tone_mode = 1'b0;
        set_keys(kbit(1, 0) | kbit(1, 2));
        wait_ticks(40);
        check(!single_tone && nvalid == v0, "R7 pulse mode", single_tone, 0);
        kmat = '0;
        wait_ticks(3);

        // R8: chip disable blinds the scanner
        chip_dis = 1'b1;
        v0 = nvalid;
        set_keys(kbit(0, 0));
        wait_ticks(2);
        check(!scan_active, "R8 no scan", scan_active, 0);
        wait_ticks(45);
        check(nvalid == v0 && !key_held, "R8 no key", nvalid - v0, 0);
        kmat = '0;
        chip_dis = 1'b0;
        wait_ticks(3);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule